// File: doc/BRIEF.md
# Coded Programmable Clock Post-Divider

This block divides a source clock by a modulus chosen from a fixed table of sixteen ratios, addressed by a 4-bit code. Two codes are presented at once, and a select input picks the one in use, so a board-level strap or a system signal can switch between two prepared output frequencies without rewriting either code. The table holds odd and large ratios as well as even ones, from 1 up to 50.

A newly selected code never cuts a period short. The divider finishes its current output period and switches only when its counter wraps. A power-down input forces the divided clock low. A separate output-enable drives the tristate enable of the output pad. Code 0 selects divide-by-1, which passes the source clock through unchanged, so an all-zero configuration gives the raw reference at the output.

Top module: `coded_post_divider`

## Requirements
- R1: The output period is N source cycles, where code values 0 to 15 select N = 1, 2, 3, 4, 5, 6, 8, 9, 10, 12, 15, 16, 18, 20, 25, 50 respectively.
- R2: With code 0 in force, `clkOut` follows `clkIn` in both clock phases.
- R3: `selHi` = 0 selects `codeLo` and `selHi` = 1 selects `codeHi` as the code for the next period.
- R4: Each period begins with the output high. The output stays high for floor(N/2) source cycles and is low for the rest, so even ratios give 50% duty.
- R5: A change of either code or of `selHi` takes effect only at the first source edge at which the current period ends. Until then, the output waveform is unchanged.
- R6: While `pwrDown` is 1, `clkOut` is 0. The internal count keeps running, so the waveform resumes in phase when `pwrDown` returns to 0.
- R7: `clkOutEn` is 1 when `outEn` is 1 and 0 when `outEn` is 0. A value of 0 means the output pad is in high impedance.
- R8: While `rstN` is 0, `clkOut` is 0. At the first rising source edge after release, a period of the selected ratio starts with the output going high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Source clock to be divided |
| rstN | input | 1 | Asynchronous active-low reset |
| codeLo | input | 4 | Ratio code used when selHi is 0 |
| codeHi | input | 4 | Ratio code used when selHi is 1 |
| selHi | input | 1 | Chooses between the two ratio codes |
| pwrDown | input | 1 | Forces the divided clock low |
| outEn | input | 1 | Output enable for the pad |
| clkOut | output | 1 | Divided clock |
| clkOutEn | output | 1 | Tristate enable for the output pad (1 = drive) |

## Verification
The tightest case is a new code or select value arriving on the same source edge at which the current period wraps. The block must then load the new ratio at once, while one edge earlier it must have ignored the change. The bench drives code and select changes at every offset within a period, including the exact wrap cycle. It also drives power-down across wrap edges. A cycle-by-cycle reference model judges both phases of every source cycle, so a ratio loaded one edge early or late, or a waveform that loses phase under power-down, shows up as a mismatch.

// File: rtl/post_div_pkg.sv
package post_div_pkg;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 6;

  typedef struct packed {
    logic             restart;
    logic             bypass;
    logic [CNT_W-1:0] lastCount;
    logic [CNT_W-1:0] curHalf;
    logic [CNT_W-1:0] newHalf;
  } divStrobe_t;

  function automatic logic [CNT_W-1:0] ratioOf(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] r;
    case (code)
      4'd0:  r = CNT_W'(1);
      4'd1:  r = CNT_W'(2);
      4'd2:  r = CNT_W'(3);
      4'd3:  r = CNT_W'(4);
      4'd4:  r = CNT_W'(5);
      4'd5:  r = CNT_W'(6);
      4'd6:  r = CNT_W'(8);
      4'd7:  r = CNT_W'(9);
      4'd8:  r = CNT_W'(10);
      4'd9:  r = CNT_W'(12);
      4'd10: r = CNT_W'(15);
      4'd11: r = CNT_W'(16);
      4'd12: r = CNT_W'(18);
      4'd13: r = CNT_W'(20);
      4'd14: r = CNT_W'(25);
      default: r = CNT_W'(50);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/post_div_ctrl.sv
module post_div_ctrl
  import post_div_pkg::*;
(
  input  logic              clkIn,
  input  logic              rstN,
  input  logic [CODE_W-1:0] codeLo,
  input  logic [CODE_W-1:0] codeHi,
  input  logic              selHi,
  input  logic              lastTick,
  output divStrobe_t        strobe
);
  logic [CNT_W-1:0] activeRatio;
  logic [CNT_W-1:0] pendRatio;

  assign pendRatio = ratioOf(selHi ? codeHi : codeLo);

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) activeRatio <= CNT_W'(1);
    else if (lastTick) activeRatio <= pendRatio;
  end

  always_comb begin
    strobe.restart   = lastTick;
    strobe.bypass    = (activeRatio == CNT_W'(1));
    strobe.lastCount = activeRatio - CNT_W'(1);
    strobe.curHalf   = activeRatio >> 1;
    strobe.newHalf   = pendRatio >> 1;
  end

  // R5: ratio may only move at a period wrap
  assert_hold_mid_period_R5: assert property (@(posedge clkIn) disable iff (!rstN)
    !lastTick |=> $stable(activeRatio));

  // R3: at a wrap the code picked by selHi is the one loaded
  assert_load_selected_R3: assert property (@(posedge clkIn) disable iff (!rstN)
    lastTick |=> activeRatio == ratioOf($past(selHi) ? $past(codeHi) : $past(codeLo)));
endmodule

// File: rtl/post_div_dp.sv
module post_div_dp
  import post_div_pkg::*;
(
  input  logic       clkIn,
  input  logic       rstN,
  input  logic       pwrDown,
  input  divStrobe_t strobe,
  output logic       lastTick,
  output logic       clkOut
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntInc;
  logic             divOut;

  assign cntInc   = cnt + CNT_W'(1);
  assign lastTick = (cnt == strobe.lastCount);

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      divOut <= 1'b0;
    end else if (strobe.restart) begin
      cnt    <= '0;
      divOut <= (strobe.newHalf != '0);
    end else begin
      cnt    <= cntInc;
      divOut <= (cntInc < strobe.curHalf);
    end
  end

  assign clkOut = rstN & ~pwrDown & (strobe.bypass ? clkIn : divOut);

  // R1: count never passes the end of the active period
  assert_count_bound_R1: assert property (@(posedge clkIn) disable iff (!rstN)
    cnt <= strobe.lastCount);

  // R4: a period of ratio 2 or more opens with the output high
  assert_start_high_R4: assert property (@(posedge clkIn) disable iff (!rstN)
    (strobe.restart && strobe.newHalf != '0) |=> divOut);
endmodule

// File: rtl/coded_post_divider.sv
module coded_post_divider
  import post_div_pkg::*;
(
  input  logic              clkIn,
  input  logic              rstN,
  input  logic [CODE_W-1:0] codeLo,
  input  logic [CODE_W-1:0] codeHi,
  input  logic              selHi,
  input  logic              pwrDown,
  input  logic              outEn,
  output logic              clkOut,
  output logic              clkOutEn
);
  divStrobe_t strobe;
  logic       lastTick;

  post_div_ctrl ctrl_i (
    .clkIn    (clkIn),
    .rstN     (rstN),
    .codeLo   (codeLo),
    .codeHi   (codeHi),
    .selHi    (selHi),
    .lastTick (lastTick),
    .strobe   (strobe)
  );

  post_div_dp dp_i (
    .clkIn    (clkIn),
    .rstN     (rstN),
    .pwrDown  (pwrDown),
    .strobe   (strobe),
    .lastTick (lastTick),
    .clkOut   (clkOut)
  );

  assign clkOutEn = outEn;
endmodule

// File: tb/coded_post_divider_tb_top.sv
module coded_post_divider_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] codeLo = 4'd5;
  logic [3:0] codeHi = 4'd0;
  logic       selHi = 1'b0;
  logic       pwrDown = 1'b0;
  logic       outEn = 1'b1;
  logic       clkOut, clkOutEn;

  int    checks = 0;
  int    errors = 0;
  string reqTag = "R8";
  logic [1:0] expQ[$];       // {divBit, bypass}

  int mRatio = 1;
  int mCnt = 0;
  logic mDiv = 1'b0;

  always #10 clk = ~clk;     // 50 MHz

  coded_post_divider dut_i (
    .clkIn(clk), .rstN(rstN), .codeLo(codeLo), .codeHi(codeHi),
    .selHi(selHi), .pwrDown(pwrDown), .outEn(outEn),
    .clkOut(clkOut), .clkOutEn(clkOutEn)
  );

  function automatic int ratioTb(input logic [3:0] c);
    case (c)
      4'd0: return 1;   4'd1: return 2;   4'd2: return 3;   4'd3: return 4;
      4'd4: return 5;   4'd5: return 6;   4'd6: return 8;   4'd7: return 9;
      4'd8: return 10;  4'd9: return 12;  4'd10: return 15; 4'd11: return 16;
      4'd12: return 18; 4'd13: return 20; 4'd14: return 25; default: return 50;
    endcase
  endfunction

  // Reference model: pushes one expected item per source edge
  always @(posedge clk) begin
    if (!rstN) begin
      mRatio = 1; mCnt = 0; mDiv = 1'b0;
    end else if (mCnt == mRatio - 1) begin
      mRatio = ratioTb(selHi ? codeHi : codeLo);
      mCnt = 0;
      mDiv = (mRatio >= 2);
    end else begin
      mCnt = mCnt + 1;
      mDiv = (mCnt < mRatio / 2);
    end
    expQ.push_back({mDiv, (mRatio == 1)});
  end

  task automatic check(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", reqTag, what, act, exp, $time);
    end
  endtask

  // Monitor: compares both phases of every cycle
  initial begin
    forever begin
      logic [1:0] item;
      logic expHi, expLo;
      @(posedge clk);
      #7;
      if (expQ.size() == 0) begin
        errors++; checks++;
        $display("FAIL %s: expected queue empty", reqTag);
        continue;
      end
      item  = expQ.pop_front();
      expHi = rstN && !pwrDown && (item[0] ? 1'b1 : item[1]);
      expLo = rstN && !pwrDown && (item[0] ? 1'b0 : item[1]);
      expHi = rstN && !pwrDown && (item[0] ? 1'b1 : item[1]);
      expLo = rstN && !pwrDown && (item[0] ? 1'b0 : item[1]);
      check("clkOut high phase", clkOut, expHi);
      check("R7 clkOutEn", clkOutEn, outEn);
      #10;
      check("clkOut low phase", clkOut, expLo);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R8: reset holds output low even though code 0 would pass the clock
    codeLo = 4'd0;
    cycles(4);
    codeLo = 4'd5;
    cycles(2);
    rstN = 1'b1;                  // first edge afterwards starts ratio 6
    reqTag = "R8";
    cycles(14);
    // R1 / R4: sweep every code through codeLo
    for (int c = 0; c < 16; c++) begin
      codeLo = 4'(c);
      reqTag = (ratioTb(4'(c)) % 2 == 1) ? "R4" : "R1";
      cycles(2 * ratioTb(4'(c)) + 3);
    end
    // R2: divide-by-1 pass-through
    reqTag = "R2";
    codeLo = 4'd0;
    cycles(60);
    cycles(8);
    // R3: select between two sets
    reqTag = "R3";
    codeLo = 4'd2; codeHi = 4'd7;
    cycles(12);
    selHi = 1'b1;
    cycles(25);
    selHi = 1'b0;
    cycles(12);
    // R5: changes at every offset inside a ratio-9 period, including the wrap
    reqTag = "R5";
    codeLo = 4'd7;
    cycles(20);
    for (int off = 0; off < 10; off++) begin
      codeLo = 4'd3;
      cycles(off + 1);
      codeLo = 4'd7;
      cycles(11);
    end
    for (int off = 0; off < 6; off++) begin
      selHi = 1'b1; codeHi = 4'd4;
      cycles(off + 1);
      selHi = 1'b0;
      cycles(10);
    end
    // R6: power-down, including across wrap edges, phase kept
    reqTag = "R6";
    codeLo = 4'd4;
    cycles(12);
    pwrDown = 1'b1;
    cycles(7);
    pwrDown = 1'b0;
    cycles(9);
    codeLo = 4'd0;
    cycles(6);
    pwrDown = 1'b1;
    cycles(4);
    pwrDown = 1'b0;
    cycles(4);
    // R7: pad enable follows outEn
    reqTag = "R7";
    codeLo = 4'd1;
    outEn = 1'b0;
    cycles(6);
    outEn = 1'b1;
    cycles(6);
    // R8: reset in the middle of a period, then restart
    reqTag = "R8";
    codeLo = 4'd8;
    cycles(13);
    rstN = 1'b0;
    cycles(3);
    rstN = 1'b1;
    cycles(25);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule